// File: doc/BRIEF.md
# Asymmetric Width Dual-Port RAM

A synchronous memory with two ports over one shared array of 2048 bits. The wide port sees the array as 256 bytes. The narrow port sees it as 512 nibbles. Each port has its own enable, write enable, address, write data and registered read data. Both ports run on one clock and may read or write in the same cycle.

Inside a byte, the nibble order is fixed. The high nibble of a byte sits at the even narrow address and the low nibble at the odd one. Data written at one width therefore reads back at the other width in a known order. The storage is kept at the narrow width. Each wide access is split into lanes, and each lane is one narrow entry.

A parameter removes the write path from the narrow port. This gives a variant in which one port writes and the other port reads.

Top module: `asym_dpram`

## Requirements
- R1: Port A has an 8-bit address and 8-bit data (256 bytes). Port B has a 9-bit address and 4-bit data (512 nibbles). Both ports cover the same 2048 bits.
- R2: Port A byte `a` occupies port B entries `2a` and `2a+1`. Bits [7:4] of the byte are at `2a`, and bits [3:0] are at `2a+1`.
- R3: A byte written on port A reads back on port B as the high nibble at the even address and the low nibble at the odd address.
- R4: Nibbles written on port B read back on port A as a byte, with the entry at `2a` in bits [7:4] and the entry at `2a+1` in bits [3:0].
- R5: Reads are synchronous. When a port's enable is high at a clock edge, its read data shows the addressed contents right after that edge.
- R6: When a port's enable is low, its read data holds its value and its write enable has no effect on the storage.
- R7: When a port writes and reads one location in the same cycle, its read data returns the contents from before the write.
- R8: When both ports write overlapping bits in the same cycle, port A's data is stored. Port B writes to a different byte in that cycle are both kept.
- R9: While the active-low asynchronous reset is low, both read data outputs are zero. The storage contents are not cleared by reset.
- R10: With parameter `WRITE_B` = 0, port B writes are ignored, and port B still reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read registers |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | 8 | Port A byte address |
| a_wdata_i | input | 8 | Port A write data |
| a_rdata_o | output | 8 | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | 9 | Port B nibble address |
| b_wdata_i | input | 4 | Port B write data |
| b_rdata_o | output | 4 | Port B registered read data |

## Verification
Each port is tested with a sweep of its own address range.

| Stimulus | What it shows |
|---|---|
| Every byte filled through port A with distinct values | Tells apart swapped nibble halves and shifted addresses |
| A full sweep of port B addresses | Tells apart swapped nibble halves and shifted addresses |
| Bytes written on port A, read back one nibble at a time on port B | Checks the cross-width order (R3) |
| Nibbles written on port B, read back as bytes on port A | Checks the cross-width order (R4) |
| Enable low with write enable high | Separates a true hold from a write that leaks through |
| Write and read of one location on one port in one cycle | Separates read-before-write from write-first |
| Both ports writing the same byte | Shows which port owns the overlap |
| Both ports writing different bytes | Shows that neither write is lost |
| Reset pulsed in the middle of a run | Shows that the read registers clear while the stored data survives |
| Mixed random traffic, with same-cycle cross-port hazards removed | Covers the ordinary cases |

A second instance, built without the narrow write path, runs the same traffic. It must keep its old contents where the full instance takes the port B writes.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;
  localparam int unsigned DEF_A_AW = 8;
  localparam int unsigned DEF_A_DW = 8;
  localparam int unsigned DEF_B_DW = 4;

  // top bit of lane k inside a wide word; lane 0 is the most significant
  function automatic int unsigned lane_msb(int unsigned a_dw, int unsigned b_dw, int unsigned k);
    return a_dw - 1 - k * b_dw;
  endfunction
endpackage

// File: rtl/asym_dpram_lane_map.sv
module asym_dpram_lane_map
  import asym_dpram_pkg::*;
#(
  parameter int unsigned A_AW  = DEF_A_AW,
  parameter int unsigned A_DW  = DEF_A_DW,
  parameter int unsigned B_DW  = DEF_B_DW,
  localparam int unsigned RATIO = A_DW / B_DW,
  localparam int unsigned SEL_W = $clog2(RATIO),
  localparam int unsigned B_AW  = A_AW + SEL_W
) (
  input  logic [A_AW-1:0]             addr_i,
  input  logic [A_DW-1:0]             wdata_i,
  input  logic [RATIO-1:0][B_DW-1:0]  rlane_i,
  output logic [RATIO-1:0][B_AW-1:0]  idx_o,
  output logic [RATIO-1:0][B_DW-1:0]  wlane_o,
  output logic [A_DW-1:0]             rdata_o
);
  for (genvar k = 0; k < RATIO; k++) begin : g_lane
    localparam int unsigned MSB = lane_msb(A_DW, B_DW, k);
    assign idx_o[k]                 = {addr_i, SEL_W'(k)};
    assign wlane_o[k]               = wdata_i[MSB -: B_DW];
    assign rdata_o[MSB -: B_DW]     = rlane_i[k];
  end
endmodule

// File: rtl/asym_dpram_core.sv
module asym_dpram_core #(
  parameter int unsigned B_AW  = 9,
  parameter int unsigned B_DW  = 4,
  parameter int unsigned RATIO = 2,
  localparam int unsigned DEPTH = 1 << B_AW
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        a_rd_i,
  input  logic                        a_wr_i,
  input  logic [RATIO-1:0][B_AW-1:0]  a_idx_i,
  input  logic [RATIO-1:0][B_DW-1:0]  a_wlane_i,
  output logic [RATIO-1:0][B_DW-1:0]  a_rlane_o,
  input  logic                        b_rd_i,
  input  logic                        b_wr_i,
  input  logic [B_AW-1:0]             b_idx_i,
  input  logic [B_DW-1:0]             b_wdata_i,
  output logic [B_DW-1:0]             b_rdata_o
);
  logic [B_DW-1:0] mem_q [DEPTH];

  // port A updates are issued last so they win on overlap
  always_ff @(posedge clk_i) begin
    if (b_wr_i) mem_q[b_idx_i] <= b_wdata_i;
    if (a_wr_i) begin
      for (int k = 0; k < RATIO; k++) mem_q[a_idx_i[k]] <= a_wlane_i[k];
    end
  end

  // registered reads see pre-write contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rlane_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_rd_i) begin
        for (int k = 0; k < RATIO; k++) a_rlane_o[k] <= mem_q[a_idx_i[k]];
      end
      if (b_rd_i) b_rdata_o <= mem_q[b_idx_i];
    end
  end
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter int unsigned A_AW    = DEF_A_AW,
  parameter int unsigned A_DW    = DEF_A_DW,
  parameter int unsigned B_DW    = DEF_B_DW,
  parameter bit          WRITE_B = 1'b1,
  localparam int unsigned RATIO  = A_DW / B_DW,
  localparam int unsigned SEL_W  = $clog2(RATIO),
  localparam int unsigned B_AW   = A_AW + SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_en_i,
  input  logic            a_we_i,
  input  logic [A_AW-1:0] a_addr_i,
  input  logic [A_DW-1:0] a_wdata_i,
  output logic [A_DW-1:0] a_rdata_o,
  input  logic            b_en_i,
  input  logic            b_we_i,
  input  logic [B_AW-1:0] b_addr_i,
  input  logic [B_DW-1:0] b_wdata_i,
  output logic [B_DW-1:0] b_rdata_o
);
  logic [RATIO-1:0][B_AW-1:0] a_idx;
  logic [RATIO-1:0][B_DW-1:0] a_wlane;
  logic [RATIO-1:0][B_DW-1:0] a_rlane;
  logic                       b_wr;

  if (WRITE_B) begin : g_b_wr
    assign b_wr = b_en_i & b_we_i;
  end else begin : g_b_ro
    assign b_wr = 1'b0;
  end

  asym_dpram_lane_map #(
    .A_AW(A_AW), .A_DW(A_DW), .B_DW(B_DW)
  ) u_map (
    .addr_i  (a_addr_i),
    .wdata_i (a_wdata_i),
    .rlane_i (a_rlane),
    .idx_o   (a_idx),
    .wlane_o (a_wlane),
    .rdata_o (a_rdata_o)
  );

  asym_dpram_core #(
    .B_AW(B_AW), .B_DW(B_DW), .RATIO(RATIO)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_rd_i    (a_en_i),
    .a_wr_i    (a_en_i & a_we_i),
    .a_idx_i   (a_idx),
    .a_wlane_i (a_wlane),
    .a_rlane_o (a_rlane),
    .b_rd_i    (b_en_i),
    .b_wr_i    (b_wr),
    .b_idx_i   (b_addr_i),
    .b_wdata_i (b_wdata_i),
    .b_rdata_o (b_rdata_o)
  );
endmodule

// File: rtl/asym_dpram_chk.sv
module asym_dpram_chk #(
  parameter int unsigned A_AW    = 8,
  parameter int unsigned A_DW    = 8,
  parameter int unsigned B_DW    = 4,
  parameter bit          WRITE_B = 1'b1,
  localparam int unsigned RATIO  = A_DW / B_DW,
  localparam int unsigned SEL_W  = $clog2(RATIO),
  localparam int unsigned B_AW   = A_AW + SEL_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            a_en_i,
  input logic            a_we_i,
  input logic [A_AW-1:0] a_addr_i,
  input logic [A_DW-1:0] a_wdata_i,
  input logic [A_DW-1:0] a_rdata_o,
  input logic            b_en_i,
  input logic            b_we_i,
  input logic [B_AW-1:0] b_addr_i,
  input logic [B_DW-1:0] b_wdata_i,
  input logic [B_DW-1:0] b_rdata_o
);
  function automatic logic [B_DW-1:0] pick(input logic [A_DW-1:0] w, input logic [SEL_W-1:0] s);
    int unsigned base;
    base = A_DW - 1 - int'(s) * B_DW;
    return w[base -: B_DW];
  endfunction

  // R6
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_en_i |=> $stable(a_rdata_o));

  // R6
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_en_i |=> $stable(b_rdata_o));

  // R3
  a_to_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i) ##1
    (b_en_i && !b_we_i && !(a_en_i && a_we_i) &&
     b_addr_i[B_AW-1:SEL_W] == $past(a_addr_i))
    |=> b_rdata_o == pick($past(a_wdata_i, 2), $past(b_addr_i[SEL_W-1:0])));

  // R8
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i && b_en_i && b_we_i && b_addr_i[B_AW-1:SEL_W] == a_addr_i) ##1
    (b_en_i && !b_we_i && !(a_en_i && a_we_i) && b_addr_i == $past(b_addr_i))
    |=> b_rdata_o == pick($past(a_wdata_i, 2), $past(b_addr_i[SEL_W-1:0])));

  if (WRITE_B) begin : g_b_chk
    // R4
    b_to_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_en_i && b_we_i && !(a_en_i && a_we_i)) ##1
      (a_en_i && !a_we_i && !(b_en_i && b_we_i) &&
       a_addr_i == $past(b_addr_i[B_AW-1:SEL_W]))
      |=> pick(a_rdata_o, $past(b_addr_i[SEL_W-1:0], 2)) == $past(b_wdata_i, 2));
  end
endmodule

bind asym_dpram asym_dpram_chk #(
  .A_AW(A_AW), .A_DW(A_DW), .B_DW(B_DW), .WRITE_B(WRITE_B)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .a_en_i(a_en_i), .a_we_i(a_we_i), .a_addr_i(a_addr_i),
  .a_wdata_i(a_wdata_i), .a_rdata_o(a_rdata_o),
  .b_en_i(b_en_i), .b_we_i(b_we_i), .b_addr_i(b_addr_i),
  .b_wdata_i(b_wdata_i), .b_rdata_o(b_rdata_o)
);

// File: tb/sim_asym_dpram.sv
module sim_asym_dpram;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       a_en_i, a_we_i;
  logic [7:0] a_addr_i, a_wdata_i;
  logic       b_en_i, b_we_i;
  logic [8:0] b_addr_i;
  logic [3:0] b_wdata_i;
  logic [7:0] a_rdata_0, a_rdata_1;
  logic [3:0] b_rdata_0, b_rdata_1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string req = "R9";

  logic [3:0] m0 [512];
  logic [3:0] m1 [512];
  logic [7:0] ea0, ea1;
  logic [3:0] eb0, eb1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  asym_dpram u0 (
    .clk_i, .rst_ni, .a_en_i, .a_we_i, .a_addr_i, .a_wdata_i, .a_rdata_o(a_rdata_0),
    .b_en_i, .b_we_i, .b_addr_i, .b_wdata_i, .b_rdata_o(b_rdata_0)
  );

  asym_dpram #(.WRITE_B(1'b0)) u1 (
    .clk_i, .rst_ni, .a_en_i, .a_we_i, .a_addr_i, .a_wdata_i, .a_rdata_o(a_rdata_1),
    .b_en_i, .b_we_i, .b_addr_i, .b_wdata_i, .b_rdata_o(b_rdata_1)
  );

  task automatic chk(string r, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%h expected=%h", r, what, $time, act, exp);
    end
  endtask

  // reference: reads take old contents, then B writes, then A writes
  task automatic model_step();
    if (!rst_ni) begin
      ea0 = '0; ea1 = '0; eb0 = '0; eb1 = '0;
      return;
    end
    if (a_en_i) begin
      ea0 = {m0[{a_addr_i, 1'b0}], m0[{a_addr_i, 1'b1}]};
      ea1 = {m1[{a_addr_i, 1'b0}], m1[{a_addr_i, 1'b1}]};
    end
    if (b_en_i) begin
      eb0 = m0[b_addr_i];
      eb1 = m1[b_addr_i];
    end
    if (b_en_i && b_we_i) m0[b_addr_i] = b_wdata_i;
    if (a_en_i && a_we_i) begin
      m0[{a_addr_i, 1'b0}] = a_wdata_i[7:4];
      m0[{a_addr_i, 1'b1}] = a_wdata_i[3:0];
      m1[{a_addr_i, 1'b0}] = a_wdata_i[7:4];
      m1[{a_addr_i, 1'b1}] = a_wdata_i[3:0];
    end
  endtask

  task automatic cyc(input logic ae, input logic awe, input logic [7:0] aa, input logic [7:0] ad,
                     input logic be, input logic bwe, input logic [8:0] ba, input logic [3:0] bd);
    @(negedge clk_i);
    a_en_i = ae; a_we_i = awe; a_addr_i = aa; a_wdata_i = ad;
    b_en_i = be; b_we_i = bwe; b_addr_i = ba; b_wdata_i = bd;
    @(posedge clk_i);
    model_step();
    #1;
    chk(req, "u0.a", a_rdata_0, ea0);
    chk(req, "u0.b", {4'h0, b_rdata_0}, {4'h0, eb0});
    chk(req, "u1.a", a_rdata_1, ea1);
    chk(req, "u1.b", {4'h0, b_rdata_1}, {4'h0, eb1});
  endtask

  task automatic idle();
    cyc(0, 0, 8'h0, 8'h0, 0, 0, 9'h0, 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    a_en_i = 0; a_we_i = 0; a_addr_i = 0; a_wdata_i = 0;
    b_en_i = 0; b_we_i = 0; b_addr_i = 0; b_wdata_i = 0;
    ea0 = 0; ea1 = 0; eb0 = 0; eb1 = 0;
    // R9: read registers at zero in reset
    req = "R9";
    idle(); idle();
    @(negedge clk_i); rst_ni = 1'b1;

    // R1: fill every byte through port A
    req = "R1";
    for (int i = 0; i < 256; i++) cyc(1, 1, 8'(i), 8'(i * 37 + 5), 0, 0, 9'h0, 4'h0);

    // R2: sweep all nibble addresses
    req = "R2";
    for (int i = 0; i < 512; i++) cyc(0, 0, 8'h0, 8'h0, 1, 0, 9'(i), 4'h0);

    // R3: byte write then nibble reads
    req = "R3";
    for (int i = 0; i < 6; i++) begin
      cyc(1, 1, 8'(i * 41 + 3), 8'hA5 ^ 8'(i * 17), 0, 0, 9'h0, 4'h0);
      cyc(0, 0, 8'h0, 8'h0, 1, 0, {8'(i * 41 + 3), 1'b0}, 4'h0);
      cyc(0, 0, 8'h0, 8'h0, 1, 0, {8'(i * 41 + 3), 1'b1}, 4'h0);
    end

    // R4: nibble writes then byte read
    req = "R4";
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 8'h0, 8'h0, 1, 1, {8'(i * 29 + 7), 1'b0}, 4'(i + 9));
      cyc(0, 0, 8'h0, 8'h0, 1, 1, {8'(i * 29 + 7), 1'b1}, 4'(i + 2));
      cyc(1, 0, 8'(i * 29 + 7), 8'h0, 0, 0, 9'h0, 4'h0);
    end

    // R5: back-to-back reads on both ports
    req = "R5";
    for (int i = 0; i < 16; i++) cyc(1, 0, 8'(i * 13), 8'h0, 1, 0, 9'(i * 31 + 1), 4'h0);

    // R6: enable low, write enable high, outputs hold and nothing written
    req = "R6";
    cyc(0, 1, 8'h10, 8'hFF, 0, 1, 9'h021, 4'hF);
    cyc(0, 1, 8'h10, 8'h00, 0, 1, 9'h021, 4'h0);
    cyc(1, 0, 8'h10, 8'h0, 1, 0, 9'h021, 4'h0);

    // R7: same-port write and read of one location
    req = "R7";
    cyc(1, 1, 8'h33, 8'h5C, 0, 0, 9'h0, 4'h0);
    cyc(1, 1, 8'h33, 8'hC3, 0, 0, 9'h0, 4'h0);
    cyc(0, 0, 8'h0, 8'h0, 1, 1, 9'h0F0, 4'h6);
    cyc(0, 0, 8'h0, 8'h0, 1, 1, 9'h0F0, 4'h9);
    cyc(1, 0, 8'h33, 8'h0, 1, 0, 9'h0F0, 4'h0);

    // R8: overlapping and disjoint simultaneous writes
    req = "R8";
    cyc(1, 1, 8'h44, 8'h12, 1, 1, 9'h088, 4'hE);
    cyc(0, 0, 8'h0, 8'h0, 1, 0, 9'h088, 4'h0);
    cyc(1, 1, 8'h45, 8'h34, 1, 1, 9'h08B, 4'hD);
    cyc(1, 0, 8'h45, 8'h0, 1, 0, 9'h08B, 4'h0);
    cyc(1, 1, 8'h50, 8'h77, 1, 1, 9'h0C1, 4'h1);
    cyc(1, 0, 8'h60, 8'h0, 1, 0, 9'h0A0, 4'h0);
    cyc(1, 0, 8'h50, 8'h0, 1, 0, 9'h0C1, 4'h0);

    // R10: narrow writes only land in the full instance
    req = "R10";
    cyc(0, 0, 8'h0, 8'h0, 1, 1, 9'h150, 4'h3);
    cyc(0, 0, 8'h0, 8'h0, 1, 1, 9'h151, 4'hB);
    cyc(1, 0, 8'hA8, 8'h0, 1, 0, 9'h150, 4'h0);
    cyc(0, 0, 8'h0, 8'h0, 1, 0, 9'h151, 4'h0);

    // R9: mid-run reset clears outputs, keeps storage
    req = "R9";
    cyc(1, 0, 8'h07, 8'h0, 1, 0, 9'h00F, 4'h0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    chk("R9", "async a", a_rdata_0, 8'h00);
    chk("R9", "async b", {4'h0, b_rdata_0}, 8'h00);
    cyc(1, 0, 8'h07, 8'h0, 1, 0, 9'h00F, 4'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(1, 0, 8'h07, 8'h0, 1, 0, 9'h00F, 4'h0);

    // R1: mixed random traffic without cross-port same-cycle hazards
    req = "R1";
    for (int i = 0; i < 600; i++) begin
      logic ae, awe, be, bwe;
      logic [7:0] aa, ad;
      logic [8:0] ba;
      logic [3:0] bd;
      ae = 1'($urandom); awe = 1'($urandom); aa = 8'($urandom); ad = 8'($urandom);
      be = 1'($urandom); bwe = 1'($urandom); ba = 9'($urandom); bd = 4'($urandom);
      if (i % 4 == 0) ba = {aa, 1'($urandom)};
      if (ae && awe && be && !bwe && ba[8:1] == aa) be = 1'b0;
      if (be && bwe && ae && !awe && ba[8:1] == aa) bwe = 1'b0;
      cyc(ae, awe, aa, ad, be, bwe, ba, bd);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule